// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier PWM Modulator

This block is the digital modulator for a single-phase seven-level stepped inverter built from seven power switches. A phase accumulator steps through a half-wave sine table to form a signed sinusoidal reference, scaled by a modulation-index input. Six triangular carriers, all sharing one up/down ramp, are stacked in equal bands from the negative peak to the positive peak. Each carrier is compared with the reference. The comparator results are reduced to an output level from -3 to +3, and that level is decoded into registered gate enables.

A two-bit select picks how the carriers are phased against each other. In the all-in-phase disposition every carrier rises together. In the opposed-halves disposition the bands below zero run on the complemented ramp. In the alternating disposition neighbouring bands are inverted in turn. A new selection takes effect only at the start of a carrier period. While reset is held, the selection is taken directly. All timing is counted in clock cycles. A carrier period is 2*HALF_TICKS cycles, and the reference period is REF_CARRIERS carrier periods. The defaults are 256 and 5120 cycles, which gives the 1:20 ratio of a 1 kHz carrier to a 50 Hz reference.

Top module: `stairPwm`

## Requirements
- R1: While rstN is low, gateOut is 0000000, and this takes effect without waiting for a clock edge. The disposition select is loaded directly while rstN is low. When rstN is released, the ramp starts at 0 and rises, and the reference phase starts at 0.
- R2: The gate bits are gateOut[0]=S1, [1]=S2, [2]=S3, [3]=S4, [4]=S5, [5]=S6, [6]=S7. Level 0 gives 0x00, +1 gives 0x45, +2 gives 0x49, +3 gives 0x51, -1 gives 0x26, -2 gives 0x2A and -3 gives 0x32.
- R3: In the first half of each reference period the level is never negative. In the second half it is never positive.
- R4: The carrier bands are BAND wide (default 640), with the full span ±3*BAND. The ramp runs 0 up to HALF_TICKS and back down, for a period of 2*HALF_TICKS cycles. With modIdx=0 the level stays 0.
- R5: The reference peak is modIdx/128 times 3*BAND. For each polarity, the level magnitude reached over a reference period is the number of bands whose inner edge the peak exceeds: modIdx 30 gives ±1, 60 gives ±2, and 102 or 128 gives ±3.
- R6: Disposition select 0 (all in phase): every carrier is its band's lower edge plus the ramp.
- R7: Select 1 or 3 (opposed halves): the three upper carriers follow the ramp, and the three lower carriers use the complemented ramp (band top minus ramp).
- R8: Select 2 (alternating): carriers are numbered 0 to 5 from the bottom band. The even-numbered carriers use the complemented ramp and the odd-numbered ones use the ramp.
- R9: A change of disposition select during operation takes effect when the ramp next returns to 0, not before.
- R10: A modIdx above 128 acts as 128.
- R11: gateOut only takes one of the seven patterns of R2, and S1 and S2 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modIdx | input | MI_W (8) | Modulation index, 128 = 1.0 (0.8 is 102) |
| dispSel | input | 2 | Carrier disposition: 0 in phase, 1 opposed halves, 2 alternating, 3 as 1 |
| gateOut | output | 7 | Registered gate enables, bit n-1 drives switch Sn |

## Verification
Two things are hard to see from the ports. The first is the phasing of each individual carrier, because the gates show only the summed level. The second is a disposition change arriving in the middle of a carrier period. Reset aligns both the ramp and the reference phase, so the bench can pick cycles close to a reference peak or trough. At those cycles one band's comparator toggles depending on whether its carrier is inverted, and the bench samples the level early and late in the same carrier period. For the mid-period case, the select is changed partway through a period. The bench then checks that the old phasing holds until the ramp wraps and that the new phasing shows in the following period.

// File: rtl/stairPwmPkg.sv
package stairPwmPkg;

  localparam int NUM_LEVELS     = 7;
  localparam int NUM_CARRIERS   = NUM_LEVELS - 1;
  localparam int BANDS_PER_SIDE = NUM_CARRIERS / 2;
  localparam int NUM_GATES      = 7;
  localparam int LEVEL_W        = 4;

  typedef enum logic [1:0] {
    DISP_PD   = 2'd0,
    DISP_POD  = 2'd1,
    DISP_APOD = 2'd2
  } dispMode_t;

  typedef logic signed [LEVEL_W-1:0] level_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                    run;      // datapath may advance and load gates
    logic [NUM_CARRIERS-1:0] invMask;  // carrier k uses the complemented ramp
  } ctrlStrobe_t;

  // Level to switch pattern: bit n-1 drives switch Sn
  function automatic logic [NUM_GATES-1:0] levelToGates(input level_t lv);
    logic [NUM_GATES-1:0] g;
    case (lv)
      4'sd1:   g = 7'b100_0101;
      4'sd2:   g = 7'b100_1001;
      4'sd3:   g = 7'b101_0001;
      -4'sd1:  g = 7'b010_0110;
      -4'sd2:  g = 7'b010_1010;
      -4'sd3:  g = 7'b011_0010;
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/stairPwmCtrl.sv
module stairPwmCtrl
  import stairPwmPkg::*;
#(
  parameter int HALF_TICKS = 128,
  parameter int RAMP_W     = $clog2(HALF_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeIn,
  output logic [RAMP_W-1:0] rampCnt,
  output dispMode_t         modeAct,
  output ctrlStrobe_t       strobe
);

  logic rampDown;
  logic runQ;
  logic [NUM_CARRIERS-1:0] invMask;

  function automatic dispMode_t sanitize(input logic [1:0] m);
    case (m)
      2'd0:    return DISP_PD;
      2'd2:    return DISP_APOD;
      default: return DISP_POD;
    endcase
  endfunction

  // Shared triangle ramp; mode is only reloaded as the ramp wraps to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampCnt  <= '0;
      rampDown <= 1'b0;
      runQ     <= 1'b0;
      modeAct  <= sanitize(modeIn);
    end else begin
      runQ <= 1'b1;
      if (!rampDown) begin
        rampCnt <= rampCnt + RAMP_W'(1);
        if (rampCnt == RAMP_W'(HALF_TICKS - 1)) rampDown <= 1'b1;
      end else begin
        rampCnt <= rampCnt - RAMP_W'(1);
        if (rampCnt == RAMP_W'(1)) begin
          rampDown <= 1'b0;
          modeAct  <= sanitize(modeIn);
        end
      end
    end
  end

  // Per-band inversion selected by the active disposition
  always_comb begin
    for (int k = 0; k < NUM_CARRIERS; k++) begin
      case (modeAct)
        DISP_PD:   invMask[k] = 1'b0;
        DISP_APOD: invMask[k] = ((k % 2) == 0);
        default:   invMask[k] = (k < BANDS_PER_SIDE);
      endcase
    end
  end

  assign strobe = '{run: runQ, invMask: invMask};

endmodule

// File: rtl/stairPwmDp.sv
module stairPwmDp
  import stairPwmPkg::*;
#(
  parameter int REF_W      = 12,
  parameter int BAND       = 640,
  parameter int HALF_TICKS = 128,
  parameter int RAMP_W     = $clog2(HALF_TICKS + 1),
  parameter int PHASE_W    = 24,
  parameter int PHASE_INC  = 3277,
  parameter int ROM_AW     = 6,
  parameter int MI_W       = 8,
  parameter int MI_ONE     = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MI_W-1:0]      modIdx,
  input  logic [RAMP_W-1:0]    rampCnt,
  input  ctrlStrobe_t          strobe,
  output logic [NUM_GATES-1:0] gateOut
);

  localparam int MAG_W   = REF_W - 1;
  localparam int ROM_N   = 2 ** ROM_AW;
  localparam int SCALE   = BAND / HALF_TICKS;
  localparam int PEAK    = BANDS_PER_SIDE * BAND;
  localparam int MI_FRAC = $clog2(MI_ONE);
  localparam int PROD_W  = MAG_W + MI_W;

  // Rational sine approximation over one half period, evaluated at elaboration
  function automatic int sineEntry(input int i, input int n, input int pk);
    longint num;
    longint den;
    num = longint'(16) * i * (n - i) * pk;
    den = longint'(5) * n * n - longint'(4) * i * (n - i);
    return int'((num + den / 2) / den);
  endfunction

  logic [MAG_W-1:0] romTab [ROM_N];

  for (genvar g = 0; g < ROM_N; g++) begin : g_rom
    localparam int ENTRY = sineEntry(g, ROM_N, PEAK);
    assign romTab[g] = MAG_W'(ENTRY);
  end

  // Reference phase
  logic [PHASE_W-1:0] phaseAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phaseAcc <= '0;
    else if (strobe.run) phaseAcc <= phaseAcc + PHASE_W'(PHASE_INC);
  end

  // Scaled, signed reference
  logic [ROM_AW-1:0]      romIdx;
  logic                   refNeg;
  logic [MI_W-1:0]        miSat;
  logic [PROD_W-1:0]      prod;
  logic [MAG_W-1:0]       mag;
  logic signed [REF_W-1:0] refVal;

  assign romIdx = phaseAcc[PHASE_W-2 -: ROM_AW];
  assign refNeg = phaseAcc[PHASE_W-1];
  assign miSat  = (modIdx > MI_W'(MI_ONE)) ? MI_W'(MI_ONE) : modIdx;
  assign prod   = {{MI_W{1'b0}}, romTab[romIdx]} * {{MAG_W{1'b0}}, miSat};
  assign mag    = prod[MI_FRAC +: MAG_W];
  assign refVal = refNeg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

  // Stacked carriers and band comparators
  int carrierVal [NUM_CARRIERS];
  logic [NUM_CARRIERS-1:0] cmpHit;

  always_comb begin
    for (int k = 0; k < NUM_CARRIERS; k++) begin
      int lowEdge;
      int rampScaled;
      lowEdge       = (k - BANDS_PER_SIDE) * BAND;
      rampScaled    = int'(rampCnt) * SCALE;
      carrierVal[k] = strobe.invMask[k] ? lowEdge + BAND - rampScaled
                                        : lowEdge + rampScaled;
      if (k >= BANDS_PER_SIDE) cmpHit[k] = int'(refVal) > carrierVal[k];
      else                     cmpHit[k] = int'(refVal) < carrierVal[k];
    end
  end

  // Level from comparator counts, clamped to the seven levels
  level_t levelNow;

  always_comb begin
    int posCnt;
    int negCnt;
    int diff;
    posCnt = 0;
    negCnt = 0;
    for (int k = 0; k < NUM_CARRIERS; k++) begin
      if (cmpHit[k]) begin
        if (k >= BANDS_PER_SIDE) posCnt++;
        else                     negCnt++;
      end
    end
    diff = posCnt - negCnt;
    if (diff > BANDS_PER_SIDE)       diff = BANDS_PER_SIDE;
    else if (diff < -BANDS_PER_SIDE) diff = -BANDS_PER_SIDE;
    levelNow = level_t'(diff);
  end

  // Registered gate enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gateOut <= '0;
    else if (strobe.run) gateOut <= levelToGates(levelNow);
  end

endmodule

// File: rtl/stairPwm.sv
module stairPwm
  import stairPwmPkg::*;
#(
  parameter int REF_W        = 12,
  parameter int BAND         = 640,
  parameter int HALF_TICKS   = 128,
  parameter int REF_CARRIERS = 20,
  parameter int PHASE_W      = 24,
  parameter int ROM_AW       = 6,
  parameter int MI_W         = 8,
  parameter int MI_ONE       = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MI_W-1:0]      modIdx,
  input  logic [1:0]           dispSel,
  output logic [NUM_GATES-1:0] gateOut
);

  localparam int RAMP_W     = $clog2(HALF_TICKS + 1);
  localparam int REF_PERIOD = 2 * HALF_TICKS * REF_CARRIERS;
  localparam int PHASE_INC  = int'(((longint'(1) << PHASE_W) + REF_PERIOD / 2) / REF_PERIOD);

  logic [RAMP_W-1:0] rampCnt;
  dispMode_t         modeAct;
  ctrlStrobe_t       strobe;

  stairPwmCtrl #(
    .HALF_TICKS(HALF_TICKS),
    .RAMP_W    (RAMP_W)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeIn (dispSel),
    .rampCnt(rampCnt),
    .modeAct(modeAct),
    .strobe (strobe)
  );

  stairPwmDp #(
    .REF_W     (REF_W),
    .BAND      (BAND),
    .HALF_TICKS(HALF_TICKS),
    .RAMP_W    (RAMP_W),
    .PHASE_W   (PHASE_W),
    .PHASE_INC (PHASE_INC),
    .ROM_AW    (ROM_AW),
    .MI_W      (MI_W),
    .MI_ONE    (MI_ONE)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .modIdx (modIdx),
    .rampCnt(rampCnt),
    .strobe (strobe),
    .gateOut(gateOut)
  );

endmodule

// File: rtl/stairPwmChk.sv
module stairPwmChk #(
  parameter int HALF_TICKS = 128,
  parameter int RAMP_W     = $clog2(HALF_TICKS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [6:0]        gateOut,
  input logic [RAMP_W-1:0] rampCnt,
  input logic [1:0]        modeAct
);

  // R1: an edge seen in reset leaves the gates all off
  a_r1_reset_off: assert property (@(posedge clk) !rstN |=> gateOut == 7'h00)
    else $error("gates not cleared by reset");

  // R11: only the seven legal switch patterns
  a_r11_legal_pattern: assert property (@(posedge clk) disable iff (!rstN)
    gateOut inside {7'h00, 7'h45, 7'h49, 7'h51, 7'h26, 7'h2A, 7'h32})
    else $error("illegal gate pattern %h", gateOut);

  // R11: the two polarity switches never conduct together
  a_r11_polarity_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(gateOut[0] && gateOut[1]))
    else $error("both polarity switches on");

  // R9: disposition only changes as the ramp returns to zero
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rampCnt != '0) |-> $stable(modeAct))
    else $error("disposition changed mid period");

  // R4: ramp never leaves its range
  a_r4_ramp_range: assert property (@(posedge clk) disable iff (!rstN)
    rampCnt <= RAMP_W'(HALF_TICKS))
    else $error("ramp out of range");

endmodule

bind stairPwm stairPwmChk #(
  .HALF_TICKS(HALF_TICKS),
  .RAMP_W    (RAMP_W)
) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .gateOut(gateOut),
  .rampCnt(rampCnt),
  .modeAct(modeAct)
);

// File: tb/test_stairPwm.sv
`timescale 1ns/1ps
module test_stairPwm;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] modIdx = 8'd0;
  logic [1:0] dispSel = 2'd1;
  logic [6:0] gateOut;

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stairPwm i_stairPwm (
    .clk    (clk),
    .rstN   (rstN),
    .modIdx (modIdx),
    .dispSel(dispSel),
    .gateOut(gateOut)
  );

  // {modIdx, dispSel, expected max level, expected min level}
  localparam int NVEC = 11;
  localparam int VEC [NVEC][4] = '{
    '{0,   1, 0,  0},
    '{30,  1, 1, -1},
    '{60,  1, 2, -2},
    '{102, 1, 3, -3},
    '{128, 0, 3, -3},
    '{60,  0, 2, -2},
    '{30,  0, 1, -1},
    '{60,  2, 2, -2},
    '{102, 2, 3, -3},
    '{255, 2, 3, -3},
    '{255, 3, 3, -3}
  };

  // R2 encoding, decoded independently; 99 marks an illegal pattern
  function automatic int gatesToLevel(input logic [6:0] g);
    case (g)
      7'h00:   return 0;
      7'h45:   return 1;
      7'h49:   return 2;
      7'h51:   return 3;
      7'h26:   return -1;
      7'h2A:   return -2;
      7'h32:   return -3;
      default: return 99;
    endcase
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int mi, input int mode);
    @(negedge clk);
    rstN    = 1'b0;
    modIdx  = 8'(mi);
    dispSel = 2'(mode);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc  = 0;
  endtask

  task automatic stepTo(input int n);
    while (cyc < n) begin
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
  endtask

  task automatic pairCheck(input string req, input int mi, input int mode,
                           input int cA, input int eA, input int cB, input int eB);
    doReset(mi, mode);
    stepTo(cA);
    chkEq(req, gatesToLevel(gateOut), eA);
    stepTo(cB);
    chkEq(req, gatesToLevel(gateOut), eB);
  endtask

  initial begin
    // R1: all off while reset held
    repeat (4) @(negedge clk);
    chkEq("R1 gates in reset", int'(gateOut), 0);

    // Table walk: one full reference period per vector
    for (int v = 0; v < NVEC; v++) begin
      int maxL;
      int minL;
      int illegal;
      int polBad;
      string tag;
      maxL = -9; minL = 9; illegal = 0; polBad = 0;
      tag = (VEC[v][0] == 0) ? "R4 zero index" :
            (VEC[v][0] > 128) ? "R10 clamped index" : "R5 level reach";
      doReset(VEC[v][0], VEC[v][1]);
      for (int c = 1; c <= 5120; c++) begin
        int lv;
        stepTo(c);
        lv = gatesToLevel(gateOut);
        if (lv == 99) illegal++;
        else begin
          if (lv > maxL) maxL = lv;
          if (lv < minL) minL = lv;
          if (c >= 16 && c <= 2540 && lv < 0) polBad++;
          if (c >= 2580 && c <= 5100 && lv > 0) polBad++;
        end
      end
      chkEq("R2/R11 illegal patterns", illegal, 0);
      chkEq({tag, " max"}, maxL, VEC[v][2]);
      chkEq({tag, " min"}, minL, VEC[v][3]);
      chkEq("R3 half-cycle polarity", polBad, 0);
    end

    // Carrier phasing probed at early and late ramp positions
    pairCheck("R6 in-phase lower band", 30, 0, 3848, 0, 3968, -1);
    pairCheck("R6 in-phase upper band", 60, 0, 1288, 2, 1408, 1);
    pairCheck("R7 opposed lower band", 30, 1, 3848, -1, 3968, 0);
    pairCheck("R7 opposed upper band", 30, 1, 1288, 1, 1408, 0);
    pairCheck("R7 opposed two lower bands", 60, 1, 3848, -2, 3968, -1);
    pairCheck("R8 alternating upper bands", 60, 2, 1288, 1, 1408, 2);
    pairCheck("R8 alternating lower bands", 60, 2, 3848, -1, 3968, -2);

    // R9: mid-period change waits for the ramp to wrap
    doReset(60, 0);
    stepTo(1300);
    dispSel = 2'd2;
    stepTo(1408);
    chkEq("R9 old disposition kept", gatesToLevel(gateOut), 1);
    stepTo(1544);
    chkEq("R9 new disposition early", gatesToLevel(gateOut), 1);
    stepTo(1664);
    chkEq("R9 new disposition late", gatesToLevel(gateOut), 2);

    // R1: asynchronous clear from an active level
    doReset(128, 1);
    stepTo(1280);
    chkEq("R5 full index at peak", gatesToLevel(gateOut), 3);
    #0.5 rstN = 1'b0;
    #0.5;
    chkEq("R1 async clear", int'(gateOut), 0);
    repeat (3) @(negedge clk);
    chkEq("R1 held clear", int'(gateOut), 0);
    rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

endmodule